// File: doc/BRIEF.md
# System Clock Control Unit

This block manages the system clock of a small microcontroller. Two registers control it. The first is a 4-bit mode register. It picks one of three oscillator sources and a divide ratio of 1, 2, 4 or 8, and it can be read back at all times. The second is a 3-bit write-only stop register. It holds one stop bit for each oscillator. Each oscillator appears as an enable output and a tick input, where the tick is a single-cycle pulse in the `clk_i` domain for each edge of that oscillator. The block emits a clock enable, `sys_ce_o`, once every N ticks of the selected source.

The block checks each register write against the other register, so the running system source can never be stopped and a stopped source can never be selected. When one field of a write is illegal, only that field is dropped; the legal fields of the same write still take effect. The stop bit of the sub-clock also drives a select output that hands two shared pins over to general port use.

Top module: `sys_clk_ctrl`

## Requirements
- R1: After reset, `mode_rdata_o` reads 4'b1100 (ring oscillator, divide by 8), `osc_en_o` is 3'b111, and `port_sel_o` is 0.
- R2: A mode write always loads bits [3:2], the divide field, and the ratio becomes 2^field (00=1, 01=2, 10=4, 11=8).
- R3: A mode write whose bits [1:0] are 2'b11 (reserved) leaves the source field unchanged.
- R4: A mode write whose bits [1:0] name an oscillator that is stopped leaves the source field unchanged. The source codes are 00=ring, 01=main, 10=sub.
- R5: A stop-register write that sets the stop bit of the currently selected source leaves that bit clear, and the other bits of the same write still update.
- R6: `osc_en_o[i]` is the inverse of stop bit i (bit 0 ring, bit 1 main, bit 2 sub). Writing 0 to a stop bit always restarts that oscillator.
- R7: `port_sel_o` is 1 exactly when stop bit 2 (sub-clock) is set.
- R8: `sys_ce_o` is asserted, in the same cycle as the tick, on every Nth tick of the selected source. Ticks of the other sources neither assert it nor advance the count.
- R9: When the source or the divide ratio changes, the tick count restarts, so the first enable after the change comes on the Nth selected tick.
- R10: When both registers are written in the same cycle, the stop write is judged against the current source, and the new source is judged against the updated stop bits.
- R11: Without a mode write, `mode_rdata_o` holds its value. Without a stop write, `osc_en_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_we_i | input | 1 | Mode register write strobe |
| mode_wdata_i | input | 4 | Mode write data: [3:2] divide, [1:0] source |
| mode_rdata_o | output | 4 | Mode register readback |
| osc_we_i | input | 1 | Stop register write strobe |
| osc_wdata_i | input | 3 | Stop bits: 1 stops the oscillator |
| osc_tick_i | input | 3 | Per-oscillator tick pulses |
| osc_en_o | output | 3 | Per-oscillator run enables |
| port_sel_o | output | 1 | Shared pins given to port use |
| sys_ce_o | output | 1 | Divided system clock enable |

## Verification
The assertions assume that the write strobes and write data are known values whenever reset is inactive, and that a tick is a single-cycle pulse. They place no rule on which oscillators tick. The bench drives every input just after a falling edge, holds each strobe for exactly one cycle, and raises each tick for a single cycle. It never overlaps a tick with a register write, so every expected enable can be tied to one known tick count.

// File: rtl/sccu_pkg.sv
package sccu_pkg;
  localparam int NUM_SRC = 3;
  localparam int SEL_W   = 2;
  localparam int DIV_W   = 2;
  localparam int CNT_W   = (1 << DIV_W) - 1;
  localparam int MODE_W  = DIV_W + SEL_W;
  localparam int SUB_IDX = 2;

  typedef logic [SEL_W-1:0] src_sel_t;
  typedef logic [DIV_W-1:0] div_sel_t;

  typedef struct packed {
    div_sel_t div;
    src_sel_t src;
  } mode_t;

  localparam src_sel_t SRC_RSVD = src_sel_t'(2'b11);

  function automatic logic [CNT_W-1:0] div_mask(div_sel_t d);
    logic [CNT_W:0] one_hot;
    one_hot = (CNT_W+1)'(1) << d;
    return CNT_W'(one_hot - 1'b1);
  endfunction
endpackage

// File: rtl/sccu_osc_ctl.sv
module sccu_osc_ctl
  import sccu_pkg::*;
#(
  parameter int N = NUM_SRC
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           we_i,
  input  logic [N-1:0]   wdata_i,
  input  src_sel_t       active_i,
  output logic [N-1:0]   stop_q_o,
  output logic [N-1:0]   stop_d_o
);
  logic [N-1:0] stop_q, stop_d;

  for (genvar i = 0; i < N; i++) begin : g_bit
    logic is_active;
    assign is_active = (active_i == src_sel_t'(i));
    // the running system source may never be stopped
    always_comb begin
      stop_d[i] = stop_q[i];
      if (we_i && !(is_active && wdata_i[i])) stop_d[i] = wdata_i[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stop_q <= '0;
    else         stop_q <= stop_d;
  end

  assign stop_q_o = stop_q;
  assign stop_d_o = stop_d;
endmodule

// File: rtl/sccu_mode_reg.sv
module sccu_mode_reg
  import sccu_pkg::*;
#(
  parameter int    N       = NUM_SRC,
  parameter mode_t RST_VAL = mode_t'(4'b1100)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  mode_t        wdata_i,
  input  logic [N-1:0] stop_nxt_i,
  output mode_t        mode_q_o,
  output mode_t        mode_d_o
);
  mode_t mode_q, mode_d;
  logic  tgt_stopped, tgt_exists, src_ok;

  always_comb begin
    tgt_stopped = 1'b0;
    tgt_exists  = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (wdata_i.src == src_sel_t'(i)) begin
        tgt_exists  = 1'b1;
        tgt_stopped = stop_nxt_i[i];
      end
    end
  end

  assign src_ok = tgt_exists && !tgt_stopped && (wdata_i.src != SRC_RSVD);

  always_comb begin
    mode_d = mode_q;
    if (we_i) begin
      mode_d.div = wdata_i.div;
      if (src_ok) mode_d.src = wdata_i.src;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= RST_VAL;
    else         mode_q <= mode_d;
  end

  assign mode_q_o = mode_q;
  assign mode_d_o = mode_d;
endmodule

// File: rtl/sccu_clk_div.sv
module sccu_clk_div
  import sccu_pkg::*;
#(
  parameter int N = NUM_SRC
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] tick_i,
  input  src_sel_t     src_i,
  input  div_sel_t     div_i,
  input  logic         clr_i,
  output logic         ce_o
);
  logic             sel_tick;
  logic [CNT_W-1:0] cnt_q, mask;

  always_comb begin
    sel_tick = 1'b0;
    for (int i = 0; i < N; i++)
      if (src_i == src_sel_t'(i)) sel_tick = tick_i[i];
  end

  assign mask = div_mask(div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (clr_i)    cnt_q <= '0;
    else if (sel_tick) cnt_q <= cnt_q + 1'b1;
  end

  assign ce_o = sel_tick && ((cnt_q & mask) == mask);
endmodule

// File: rtl/sys_clk_ctrl.sv
module sys_clk_ctrl
  import sccu_pkg::*;
#(
  parameter int                N        = NUM_SRC,
  parameter logic [MODE_W-1:0] MODE_RST = 4'b1100
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_we_i,
  input  logic [MODE_W-1:0] mode_wdata_i,
  output logic [MODE_W-1:0] mode_rdata_o,
  input  logic              osc_we_i,
  input  logic [N-1:0]      osc_wdata_i,
  input  logic [N-1:0]      osc_tick_i,
  output logic [N-1:0]      osc_en_o,
  output logic              port_sel_o,
  output logic              sys_ce_o
);
  mode_t        mode_q, mode_d;
  logic [N-1:0] stop_q, stop_d;

  sccu_osc_ctl #(.N(N)) u_osc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (osc_we_i),
    .wdata_i  (osc_wdata_i),
    .active_i (mode_q.src),
    .stop_q_o (stop_q),
    .stop_d_o (stop_d)
  );

  sccu_mode_reg #(.N(N), .RST_VAL(mode_t'(MODE_RST))) u_mode (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (mode_we_i),
    .wdata_i    (mode_t'(mode_wdata_i)),
    .stop_nxt_i (stop_d),
    .mode_q_o   (mode_q),
    .mode_d_o   (mode_d)
  );

  sccu_clk_div #(.N(N)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (osc_tick_i),
    .src_i  (mode_q.src),
    .div_i  (mode_q.div),
    .clr_i  (mode_d != mode_q),
    .ce_o   (sys_ce_o)
  );

  assign mode_rdata_o = mode_q;
  assign osc_en_o     = ~stop_q;
  assign port_sel_o   = stop_q[SUB_IDX];
endmodule

// File: rtl/sys_clk_ctrl_chk.sv
module sys_clk_ctrl_chk
  import sccu_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mode_we_i,
  input logic [MODE_W-1:0] mode_wdata_i,
  input logic [MODE_W-1:0] mode_rdata_o,
  input logic              osc_we_i,
  input logic [NUM_SRC-1:0] osc_tick_i,
  input logic [NUM_SRC-1:0] osc_en_o,
  input logic              sys_ce_o
);
  logic [NUM_SRC-1:0] sel_bit;
  assign sel_bit = NUM_SRC'(1) << mode_rdata_o[SEL_W-1:0];

  p_no_reserved_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_rdata_o[SEL_W-1:0] != SRC_RSVD);

  p_active_running_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |(osc_en_o & sel_bit));

  p_div_loaded_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_we_i |=> mode_rdata_o[MODE_W-1:SEL_W] == $past(mode_wdata_i[MODE_W-1:SEL_W]));

  p_mode_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_we_i |=> $stable(mode_rdata_o));

  p_osc_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !osc_we_i |=> $stable(osc_en_o));

  p_ce_needs_tick_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_ce_o |-> |(osc_tick_i & sel_bit));
endmodule

bind sys_clk_ctrl sys_clk_ctrl_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .mode_we_i    (mode_we_i),
  .mode_wdata_i (mode_wdata_i),
  .mode_rdata_o (mode_rdata_o),
  .osc_we_i     (osc_we_i),
  .osc_tick_i   (osc_tick_i),
  .osc_en_o     (osc_en_o),
  .sys_ce_o     (sys_ce_o)
);

// File: tb/sys_clk_ctrl_test.sv
module sys_clk_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_we = 1'b0;
  logic [3:0] mode_wdata = '0;
  logic [3:0] mode_rdata;
  logic       osc_we = 1'b0;
  logic [2:0] osc_wdata = '0;
  logic [2:0] osc_tick = '0;
  logic [2:0] osc_en;
  logic       port_sel;
  logic       sys_ce;

  int total = 0;
  int fails = 0;

  always #5 clk = ~clk;

  sys_clk_ctrl uut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .mode_we_i    (mode_we),
    .mode_wdata_i (mode_wdata),
    .mode_rdata_o (mode_rdata),
    .osc_we_i     (osc_we),
    .osc_wdata_i  (osc_wdata),
    .osc_tick_i   (osc_tick),
    .osc_en_o     (osc_en),
    .port_sel_o   (port_sel),
    .sys_ce_o     (sys_ce)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr_mode(logic [3:0] d);
    @(negedge clk); mode_we = 1'b1; mode_wdata = d;
    @(negedge clk); mode_we = 1'b0;
  endtask

  task automatic wr_osc(logic [2:0] d);
    @(negedge clk); osc_we = 1'b1; osc_wdata = d;
    @(negedge clk); osc_we = 1'b0;
  endtask

  task automatic wr_both(logic [3:0] m, logic [2:0] o);
    @(negedge clk); mode_we = 1'b1; mode_wdata = m; osc_we = 1'b1; osc_wdata = o;
    @(negedge clk); mode_we = 1'b0; osc_we = 1'b0;
  endtask

  task automatic tick(int s, logic exp_ce, string req);
    @(negedge clk); osc_tick = 3'(1 << s);
    #1 check(req, 8'(sys_ce), 8'(exp_ce));
    @(negedge clk); osc_tick = '0;
  endtask

  task automatic run_ticks(int s, int n, int period, string req);
    for (int i = 1; i <= n; i++) tick(s, (i % period) == 0, req);
  endtask

  task automatic t_reset;
    check("R1 mode", 8'(mode_rdata), 8'hC);
    check("R1 osc_en", 8'(osc_en), 8'h7);
    check("R1 port", 8'(port_sel), 8'h0);
  endtask

  task automatic t_divide;
    run_ticks(0, 8, 8, "R8 div8");
    wr_mode(4'b0100);
    check("R2 div2 readback", 8'(mode_rdata), 8'h4);
    run_ticks(0, 4, 2, "R2 div2");
    tick(1, 1'b0, "R8 other src");
    tick(2, 1'b0, "R8 other src");
    tick(0, 1'b0, "R8 count not advanced");
    tick(0, 1'b1, "R8 count not advanced");
    wr_mode(4'b0000);
    run_ticks(0, 3, 1, "R2 div1");
  endtask

  task automatic t_clear;
    wr_mode(4'b1100);
    run_ticks(0, 3, 8, "R9 pre");
    wr_mode(4'b1000);
    run_ticks(0, 4, 4, "R9 restart after change");
  endtask

  task automatic t_reserved;
    wr_mode(4'b0111);
    check("R3 reserved src dropped", 8'(mode_rdata), 8'h4);
  endtask

  task automatic t_stop_active;
    wr_osc(3'b011);
    check("R5 active not stopped", 8'(osc_en), 8'h5);
    check("R11 mode untouched", 8'(mode_rdata), 8'h4);
  endtask

  task automatic t_select_stopped;
    wr_mode(4'b0001);
    check("R4 stopped src dropped", 8'(mode_rdata), 8'h0);
    wr_mode(4'b0010);
    check("R4 running src taken", 8'(mode_rdata), 8'h2);
    wr_mode(4'b0000);
    check("R4 back to ring", 8'(mode_rdata), 8'h0);
  endtask

  task automatic t_port;
    wr_osc(3'b100);
    check("R6 main restarted", 8'(osc_en), 8'h3);
    check("R7 port select on", 8'(port_sel), 8'h1);
    wr_osc(3'b000);
    check("R6 all running", 8'(osc_en), 8'h7);
    check("R7 port select off", 8'(port_sel), 8'h0);
  endtask

  task automatic t_same_cycle;
    wr_both(4'b0101, 3'b010);
    check("R10 select of newly stopped", 8'(mode_rdata), 8'h4);
    check("R10 stop applied", 8'(osc_en), 8'h5);
    wr_both(4'b0001, 3'b000);
    check("R10 select of newly started", 8'(mode_rdata), 8'h1);
    check("R10 start applied", 8'(osc_en), 8'h7);
    wr_both(4'b0000, 3'b001);
    check("R10 old src stopped, switch dropped", 8'(mode_rdata), 8'h1);
    check("R10 ring stop applied", 8'(osc_en), 8'h6);
    tick(1, 1'b1, "R8 main div1");
    tick(0, 1'b0, "R8 ring ignored");
  endtask

  initial begin
    #200000;
    fails++;
    total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #23 rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_divide;
    t_clear;
    t_reserved;
    t_stop_active;
    t_select_stopped;
    t_port;
    t_same_cycle;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule